// File: doc/BRIEF.md
# Programmable Read-Only Memory Control and Identifier Model

This block is a synthesizable, cycle-based model of the control side of a byte-wide, ultraviolet-erasable programmable read-only memory. Its purpose is to act as a stand-in device when testing programmer sequencers and read controllers. On every clock edge it samples the active-low select, output-gate and program-enable pins. It also samples two level flags: one says the programming supply is present, the other says the identification high voltage is on address line nine. From these it decides which of eight operating modes applies. The decided mode, an error flag, the data byte and a data-drive qualifier all appear on registered outputs one clock later. The qualifier takes the place of a tri-state enable.

A small array of words backs the model. Reset erases it, so every bit reads one. A program strobe can only clear bits. In identification mode the block returns two fixed bytes chosen by address bit zero. The parity bit of each byte is computed from a 7-bit code parameter. The interface is level-sensitive and has no valid/ready handshake. Because of that there is no back-pressure: the block accepts a new pin state on every clock and never stalls the caller.

Top module: `eprom_ctl_model`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `dout_en`=0, `dout`=0, `mode`=0 and `err`=0. Reset sets every word of the array to 8'hFF.
- R2: With `vpp_hi`=0 and `ce_n`=1, `mode` becomes 0 (standby) one clock later and `dout_en`=0, whatever `oe_n`, `pgm_n` and `a9_hv` are.
- R3: With `vpp_hi`=0, `ce_n`=0, `pgm_n`=1 and `oe_n`=1, `mode` becomes 1 (output off) one clock later and `dout_en`=0.
- R4: With `vpp_hi`=0, `ce_n`=0, `oe_n`=0, `pgm_n`=1 and `a9_hv`=0, `mode` becomes 2 (read) one clock later, with `dout_en`=1 and `dout` equal to the stored word at `addr`.
- R5: With `vpp_hi`=1, `ce_n`=0, `oe_n`=1 and `pgm_n`=0, `mode` is 4 (program) and `dout_en`=0. Each 0-to-1 change of `prog_strobe` between consecutive clock samples writes stored AND `din` at `addr`. Holding the strobe high writes nothing more.
- R6: Programming can never turn a stored 0 into 1. A strobe with `din`=8'hFF leaves the word unchanged.
- R7: With `vpp_hi`=1, `ce_n`=0, `oe_n`=0 and `pgm_n`=1, `mode` becomes 5 (verify) one clock later, with `dout_en`=1 and `dout` equal to the stored word.
- R8: With `vpp_hi`=1 and `a9_hv`=0, `ce_n`=1 gives `mode` 6 (inhibit) and `dout_en`=0. Strobe edges then change no stored word.
- R9: With `vpp_hi`=0, `ce_n`=0, `oe_n`=0, `pgm_n`=1, `a9_hv`=1 and `addr[AW-1:1]`=0, `mode` becomes 3 (identify). `dout` is 8'h01 when `addr[0]`=0 and 8'h97 when `addr[0]`=1.
- R10: Each identification byte has odd parity over all eight bits. Bit 7 is the parity bit, derived from the 7-bit code parameter.
- R11: The following give `mode` 7 and `err`=1 one clock later, with `dout_en`=0 and no write from strobe edges. In every other mode `err`=0. The cases are:
  - `vpp_hi` and `a9_hv` both 1;
  - `vpp_hi`=0, `ce_n`=0 and `pgm_n`=0;
  - `vpp_hi`=1, `ce_n`=0 and `oe_n` equal to `pgm_n`;
  - identification with any of `addr[AW-1:1]` nonzero.
- R12: Whenever `dout_en` is 0, `dout` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset; erases the array |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low program enable |
| vpp_hi | input | 1 | Programming supply present |
| a9_hv | input | 1 | Identification high voltage present on address line nine |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| din | input | 8 | Byte to program |
| prog_strobe | input | 1 | Program pulse; acts on its rising change |
| dout | output | 8 | Registered data byte |
| dout_en | output | 1 | High when the model would drive the data bus |
| mode | output | 3 | Registered mode code (0..7 as in the requirements) |
| err | output | 1 | Registered illegal-combination flag |

## Verification
A wrong stored word stays hidden until the next read or verify of that address, and then shows on `dout` exactly one clock later. This is why the stimulus reads back every address that a program, inhibit or illegal cycle might have touched. A faulty mode decision appears on `mode`, `err` and `dout_en` on the very next edge. A faulty strobe edge detector shows up only through the stored value, so held-high strobes are followed by verify reads.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_STANDBY = 3'd0,
    MD_OUT_OFF = 3'd1,
    MD_READ    = 3'd2,
    MD_IDENT   = 3'd3,
    MD_PROG    = 3'd4,
    MD_VERIFY  = 3'd5,
    MD_INHIBIT = 3'd6,
    MD_ILLEGAL = 3'd7
  } mode_e;

  // append an odd-parity bit above a 7-bit code
  function automatic logic [BYTE_W-1:0] with_odd_parity(input logic [BYTE_W-2:0] code);
    return {~(^code), code};
  endfunction
endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
  import eprom_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  pgm_n,
  input  logic  vpp_hi,
  input  logic  a9_hv,
  input  logic  addr_hi_zero,
  output mode_e mode
);
  always_comb begin
    mode = MD_ILLEGAL;
    if (vpp_hi && a9_hv) begin
      mode = MD_ILLEGAL;
    end else if (vpp_hi) begin
      if (ce_n)                mode = MD_INHIBIT;
      else if (oe_n && !pgm_n) mode = MD_PROG;
      else if (!oe_n && pgm_n) mode = MD_VERIFY;
      else                     mode = MD_ILLEGAL;
    end else begin
      if (ce_n)                mode = MD_STANDBY;
      else if (!pgm_n)         mode = MD_ILLEGAL;
      else if (oe_n)           mode = MD_OUT_OFF;
      else if (a9_hv)          mode = addr_hi_zero ? MD_IDENT : MD_ILLEGAL;
      else                     mode = MD_READ;
    end
  end
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
  import eprom_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] word_q [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q[w] <= '1;                       // erased state
      else if (wr_en && (addr == AW'(w)))
        word_q[w] <= word_q[w] & din;          // bits may only fall
    end
  end

  always_comb begin
    rdata = '1;
    for (int i = 0; i < DEPTH; i++)
      if (addr == AW'(i)) rdata = word_q[i];
  end
endmodule

// File: rtl/eprom_id_rom.sv
module eprom_id_rom
  import eprom_pkg::*;
#(
  parameter logic [BYTE_W-2:0] MFR_CODE7 = 7'h01,
  parameter logic [BYTE_W-2:0] DEV_CODE7 = 7'h17
) (
  input  logic              sel_dev,
  output logic [BYTE_W-1:0] id_byte
);
  localparam logic [BYTE_W-1:0] MFR_BYTE = with_odd_parity(MFR_CODE7);
  localparam logic [BYTE_W-1:0] DEV_BYTE = with_odd_parity(DEV_CODE7);

  assign id_byte = sel_dev ? DEV_BYTE : MFR_BYTE;
endmodule

// File: rtl/eprom_ctl_model.sv
module eprom_ctl_model
  import eprom_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter logic [6:0] MFR_CODE7 = 7'h01,
  parameter logic [6:0] DEV_CODE7 = 7'h17,
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          pgm_n,
  input  logic          vpp_hi,
  input  logic          a9_hv,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          prog_strobe,
  output logic [7:0]    dout,
  output logic          dout_en,
  output logic [2:0]    mode,
  output logic          err
);
  mode_e             mode_c;
  logic              addr_hi_zero;
  logic              strobe_q;
  logic              wr_en;
  logic [BYTE_W-1:0] rdata;
  logic [BYTE_W-1:0] id_byte;
  logic [BYTE_W-1:0] dout_c;
  logic              den_c;

  if (AW > 1) begin : g_hi
    assign addr_hi_zero = (addr[AW-1:1] == '0);
  end else begin : g_nohi
    assign addr_hi_zero = 1'b1;
  end

  eprom_mode_decode u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .vpp_hi(vpp_hi),
    .a9_hv(a9_hv), .addr_hi_zero(addr_hi_zero), .mode(mode_c)
  );

  assign wr_en = (mode_c == MD_PROG) && prog_strobe && !strobe_q;

  eprom_cell_array #(.DEPTH(DEPTH)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .din(din), .rdata(rdata)
  );

  eprom_id_rom #(.MFR_CODE7(MFR_CODE7), .DEV_CODE7(DEV_CODE7)) u_id (
    .sel_dev(addr[0]), .id_byte(id_byte)
  );

  always_comb begin
    den_c  = 1'b0;
    dout_c = '0;
    unique case (mode_c)
      MD_READ, MD_VERIFY: begin den_c = 1'b1; dout_c = rdata;   end
      MD_IDENT:           begin den_c = 1'b1; dout_c = id_byte; end
      default:            begin den_c = 1'b0; dout_c = '0;      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      dout     <= '0;
      dout_en  <= 1'b0;
      mode     <= MD_STANDBY;
      err      <= 1'b0;
    end else begin
      strobe_q <= prog_strobe;
      dout     <= dout_c;
      dout_en  <= den_c;
      mode     <= mode_c;
      err      <= (mode_c == MD_ILLEGAL);
    end
  end
endmodule

// File: rtl/eprom_ctl_checker.sv
module eprom_ctl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       vpp_hi,
  input logic       a9_hv,
  input logic [7:0] dout,
  input logic       dout_en,
  input logic [2:0] mode,
  input logic       err
);
  AST_FLOAT_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == 8'h00)); // R12
  AST_ERR_MATCHES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    err == (mode == 3'd7)); // R11
  AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> (^dout == 1'b1)); // R10
  AST_STANDBY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !vpp_hi) |=> (mode == 3'd0 && !dout_en)); // R2
  AST_INHIBIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && vpp_hi && !a9_hv) |=> (mode == 3'd6 && !dout_en)); // R8
  AST_NO_DRIVE_OFF_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 || mode == 3'd4) |-> !dout_en); // R3
endmodule

bind eprom_ctl_model eprom_ctl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .vpp_hi(vpp_hi), .a9_hv(a9_hv),
  .dout(dout), .dout_en(dout_en), .mode(mode), .err(err)
);

// File: tb/tb_eprom_ctl_model.sv
`timescale 1ns/1ps
module tb_eprom_ctl_model;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ce_n, oe_n, pgm_n, vpp_hi, a9_hv, prog_strobe;
  logic [AW-1:0] addr;
  logic [7:0] din;
  logic [7:0] dout;
  logic dout_en, err;
  logic [2:0] mode;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  int mem_m [DEPTH];
  bit prev_st = 0;

  always #5 clk = ~clk;

  eprom_ctl_model #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr), .din(din),
    .prog_strobe(prog_strobe), .dout(dout), .dout_en(dout_en),
    .mode(mode), .err(err)
  );

  function automatic int ref_mode(bit ce, bit oe, bit pg, bit vp, bit a9, int a);
    if (vp && a9) return 7;
    if (vp) begin
      if (ce) return 6;
      if (oe && !pg) return 4;
      if (!oe && pg) return 5;
      return 7;
    end
    if (ce) return 0;
    if (!pg) return 7;
    if (oe) return 1;
    if (a9) return (a / 2 == 0) ? 3 : 7;
    return 2;
  endfunction

  task automatic check(string tag, int em, bit ee, bit een, int ed);
    compared++;
    if (mode !== 3'(em) || err !== ee || dout_en !== een || dout !== 8'(ed)) begin
      mismatched++;
      $display("FAIL %s: actual mode=%0d err=%0b en=%0b dout=%02h expected mode=%0d err=%0b en=%0b dout=%02h",
               tag, mode, err, dout_en, dout, em, ee, een, 8'(ed));
    end
  endtask

  task automatic step(string tag, bit ce, bit oe, bit pg, bit vp, bit a9,
                      int a, int d, bit st);
    int m; bit en; int ed;
    @(negedge clk);
    ce_n = ce; oe_n = oe; pgm_n = pg; vpp_hi = vp; a9_hv = a9;
    addr = AW'(a); din = 8'(d); prog_strobe = st;
    m = ref_mode(ce, oe, pg, vp, a9, a);
    en = (m == 2 || m == 3 || m == 5);
    ed = 0;
    if (m == 2 || m == 5) ed = mem_m[a];
    if (m == 3) ed = (a % 2 == 1) ? 8'h97 : 8'h01;
    if (m == 4 && st && !prev_st) mem_m[a] = mem_m[a] & d;
    prev_st = st;
    @(posedge clk); #1;
    check(tag, m, (m == 7), en, ed);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
    rst_n = 0; ce_n = 1; oe_n = 1; pgm_n = 1; vpp_hi = 0; a9_hv = 0;
    addr = '0; din = '0; prog_strobe = 0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset", 0, 0, 0, 0);
    @(negedge clk); rst_n = 1;
    // R1: erased contents
    for (int a = 0; a < DEPTH; a++) step("R1 erased read", 0, 0, 1, 0, 0, a, 0, 0);
    // R2: standby ignores oe, pgm, a9
    step("R2 standby oe low", 1, 0, 1, 0, 0, 2, 0, 0);
    step("R2 standby pgm low a9", 1, 0, 0, 0, 1, 2, 0, 1);
    step("R2 standby oe high", 1, 1, 1, 0, 0, 2, 0, 0);
    // R3
    step("R3 output off", 0, 1, 1, 0, 0, 2, 0, 0);
    step("R3 output off a9", 0, 1, 1, 0, 1, 5, 0, 0);
    // R5 program with edge, then held strobe
    step("R5 program idle", 0, 1, 0, 1, 0, 3, 8'hA5, 0);
    step("R5 program edge", 0, 1, 0, 1, 0, 3, 8'hA5, 1);
    step("R5 program held", 0, 1, 0, 1, 0, 3, 8'h00, 1);
    step("R5 program held", 0, 1, 0, 1, 0, 3, 8'h00, 1);
    step("R7 verify", 0, 0, 1, 1, 0, 3, 0, 0);
    // R6: cannot raise bits
    step("R6 program ff low", 0, 1, 0, 1, 0, 3, 8'hFF, 0);
    step("R6 program ff edge", 0, 1, 0, 1, 0, 3, 8'hFF, 1);
    step("R6 verify", 0, 0, 1, 1, 0, 3, 0, 0);
    step("R6 program 0f low", 0, 1, 0, 1, 0, 3, 8'h0F, 0);
    step("R6 program 0f edge", 0, 1, 0, 1, 0, 3, 8'h0F, 1);
    step("R4 read back", 0, 0, 1, 0, 0, 3, 0, 0);
    step("R4 read other", 0, 0, 1, 0, 0, 4, 0, 0);
    // R8 inhibit
    step("R8 inhibit", 1, 1, 0, 1, 0, 5, 8'h00, 0);
    step("R8 inhibit edge", 1, 1, 0, 1, 0, 5, 8'h00, 1);
    step("R8 inhibit low", 1, 1, 0, 1, 0, 5, 8'h00, 0);
    step("R8 inhibit edge", 1, 0, 0, 1, 0, 5, 8'h00, 1);
    step("R8 read untouched", 0, 0, 1, 0, 0, 5, 0, 0);
    // R9, R10 identification
    step("R9 R10 mfr id", 0, 0, 1, 0, 1, 0, 0, 0);
    step("R9 R10 dev id", 0, 0, 1, 0, 1, 1, 0, 0);
    step("R11 id high addr", 0, 0, 1, 0, 1, 2, 0, 0);
    // R11 illegal combos, strobe edges ignored
    step("R11 pgm w/o vpp", 0, 1, 0, 0, 0, 6, 8'h00, 0);
    step("R11 pgm w/o vpp edge", 0, 1, 0, 0, 0, 6, 8'h00, 1);
    step("R11 vpp and a9", 0, 1, 0, 1, 1, 6, 8'h00, 0);
    step("R11 vpp and a9 edge", 0, 1, 0, 1, 1, 6, 8'h00, 1);
    step("R11 vpp oe=pgm", 0, 0, 0, 1, 0, 6, 8'h00, 0);
    step("R11 vpp oe=pgm edge", 0, 0, 0, 1, 0, 6, 8'h00, 1);
    step("R11 vpp oe=pgm high", 0, 1, 1, 1, 0, 6, 8'h00, 0);
    step("R11 read untouched", 0, 0, 1, 0, 0, 6, 0, 0);
    // R12 and R4 over a mixed pattern
    for (int a = 0; a < DEPTH; a++) begin
      step("R5 program sweep low", 0, 1, 0, 1, 0, a, (a * 37) & 8'hFF, 0);
      step("R5 program sweep edge", 0, 1, 0, 1, 0, a, (a * 37) & 8'hFF, 1);
    end
    for (int a = 0; a < DEPTH; a++) step("R4 R12 sweep read", 0, (a % 3 == 0), 1, 0, 0, a, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule